// File: doc/BRIEF.md
# Mailbox Threshold Interrupt Controller

This block is the interrupt logic for one side of a two-processor mailbox. Each cycle it compares the fill level of the outgoing (send) FIFO and the incoming (receive) FIFO with two programmable thresholds. From each comparison it keeps a registered "active" flag. A rising edge on either flag latches a status bit. Error pulses from the FIFO access logic latch a third status bit. The status bits are masked by an enable register, and the OR of the surviving bits drives a single level-sensitive interrupt line.

Software reaches the thresholds, status, enable and pending values through a small register port. Status bits are cleared by writing a 1. Because the status bits follow edges of level comparisons, rewriting a threshold can raise an interrupt even when no FIFO level moves. The FIFOs themselves and any bus adapter sit outside this block.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: The receive-active output `rcv_act` is 1 exactly when `rcv_level` is strictly greater than the receive threshold. It is registered, so it reflects the inputs one clock edge later.
- R2: The send-active output `snd_act` is 1 exactly when `snd_level` is less than or equal to the send threshold, and 0 when the level is greater. It is registered in the same way as `rcv_act`.
- R3: Both thresholds are log2(DEPTH) bits wide and reset to 0. A write keeps only the low log2(DEPTH) bits of `reg_wdata`, and a read returns the value zero-extended.
- R4: Status bit 0 is set on the edge where `snd_act` rises from 0 to 1. Status bit 1 is set on the edge where `rcv_act` rises. After reset, the levels and thresholds are 0, so bit 0 sets on the first edge.
- R5: Status bit 2 is set on the edge after any bit of `err_evt` is 1.
- R6: Writing the status address clears every status bit whose `reg_wdata` bit is 1. Bits written with 0, and bits that are already clear, are unchanged.
- R7: When a set event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R8: The pending value equals status AND enable. It is read-only, so writes to its address have no effect. The enable register keeps only bits [2:0].
- R9: `irq` is the OR of the pending bits, registered one cycle after the status or enable change that causes it. `irq` stays 0 while enable is 0.
- R10: Writing a new threshold alone, with the FIFO levels held constant, can produce a rising edge on an active flag and so set a status bit.
- R11: Register addresses on `reg_addr` are: 0 send threshold, 1 receive threshold, 2 status, 3 enable, 4 pending. Any other address reads 0. `reg_rdata` is registered: it shows the register selected by `reg_addr` one edge after that address is applied.
- R12: During reset, `irq`, `snd_act`, `rcv_act` and `reg_rdata` are 0. Enable and both thresholds come out of reset as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_level | input | log2(DEPTH)+1 | Send FIFO fill level |
| rcv_level | input | log2(DEPTH)+1 | Receive FIFO fill level |
| err_evt | input | ERR_W | Error event pulses, one bit per error kind |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for `reg_addr` |
| snd_act | output | 1 | Registered send-threshold-active flag |
| rcv_act | output | 1 | Registered receive-threshold-active flag |
| irq | output | 1 | Level interrupt request |

## Verification
A stale copy of an active flag shows up in two ways. Either a status bit fails to set on a true crossing, or a status bit sets when nothing crossed. Both appear in the status readback and on `irq`, at most two edges after the level or threshold change. A wrong clear or set priority leaves a status bit in the wrong state, and the next status read shows it. A broken mask shows up on the pending readback, or on `irq` one edge after enable or status changes. The bench walks each comparison across its equality boundary and triggers a crossing through a threshold write alone. It also collides an error pulse with a clear, and reads every register after each step.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_SRC  = 3;

  // status / enable / pending bit positions
  localparam int unsigned B_SND = 0;
  localparam int unsigned B_RCV = 1;
  localparam int unsigned B_ERR = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_SND_THR = 3'd0,
    A_RCV_THR = 3'd1,
    A_STATUS  = 3'd2,
    A_ENABLE  = 3'd3,
    A_PEND    = 3'd4
  } mic_addr_e;
endpackage

// File: rtl/mic_level_cmp.sv
// Level-versus-threshold comparator with a registered flag and rise detect.
// ABOVE=1: flag when level > thr. ABOVE=0: flag when level <= thr.
module mic_level_cmp #(
  parameter int unsigned TH_W  = 4,
  parameter int unsigned LVL_W = TH_W + 1,
  parameter bit          ABOVE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [TH_W-1:0]  thr,
  output logic             act_q,
  output logic             rise
);
  logic [LVL_W-1:0] thr_ext;
  logic             act_now;

  assign thr_ext = {{(LVL_W-TH_W){1'b0}}, thr};

  generate
    if (ABOVE) begin : g_above
      assign act_now = (level > thr_ext);
    end else begin : g_at_or_below
      assign act_now = (level <= thr_ext);
    end
  endgenerate

  assign rise = act_now & ~act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act_now;
  end

  // a detected rise must be visible on the registered flag next cycle
  p_rise_flag_r4: assert property (@(posedge clk) disable iff (rst)
    rise |=> act_q);
endmodule

// File: rtl/mic_status_bank.sv
// Sticky status bits (set on event, write-1 clear, set wins), enable mask, irq.
module mic_status_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] sts_q,
  output logic [N-1:0] en_q,
  output logic         irq_q
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)                           sts_q[gi] <= 1'b0;
        else if (set_ev[gi])               sts_q[gi] <= 1'b1;
        else if (clr_we && clr_mask[gi])   sts_q[gi] <= 1'b0;
      end

      p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        set_ev[gi] |=> sts_q[gi]);
      p_w1c_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_mask[gi] && !set_ev[gi]) |=> !sts_q[gi]);
      p_hold_set_r6: assert property (@(posedge clk) disable iff (rst)
        (sts_q[gi] && !(clr_we && clr_mask[gi])) |=> sts_q[gi]);
      p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        (!sts_q[gi] && !set_ev[gi]) |=> !sts_q[gi]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(sts_q & en_q);
  end

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_q);
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mic_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ERR_W  = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned TH_W  = $clog2(DEPTH),
  localparam int unsigned LVL_W = TH_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  snd_level,
  input  logic [LVL_W-1:0]  rcv_level,
  input  logic [ERR_W-1:0]  err_evt,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              snd_act,
  output logic              rcv_act,
  output logic              irq
);
  logic [TH_W-1:0]  snd_thr_q, rcv_thr_q;
  logic             snd_rise, rcv_rise;
  logic [N_SRC-1:0] set_ev, sts, en, pend;
  logic             wr_sts, wr_en;
  logic [DATA_W-1:0] unused_wdata_hi;

  assign unused_wdata_hi = reg_wdata;

  // threshold registers
  always_ff @(posedge clk) begin
    if (rst) begin
      snd_thr_q <= '0;
      rcv_thr_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_SND_THR) snd_thr_q <= reg_wdata[TH_W-1:0];
      if (reg_addr == A_RCV_THR) rcv_thr_q <= reg_wdata[TH_W-1:0];
    end
  end

  mic_level_cmp #(.TH_W(TH_W), .LVL_W(LVL_W), .ABOVE(1'b0)) u_snd_cmp (
    .clk(clk), .rst(rst), .level(snd_level), .thr(snd_thr_q),
    .act_q(snd_act), .rise(snd_rise));

  mic_level_cmp #(.TH_W(TH_W), .LVL_W(LVL_W), .ABOVE(1'b1)) u_rcv_cmp (
    .clk(clk), .rst(rst), .level(rcv_level), .thr(rcv_thr_q),
    .act_q(rcv_act), .rise(rcv_rise));

  always_comb begin
    set_ev        = '0;
    set_ev[B_SND] = snd_rise;
    set_ev[B_RCV] = rcv_rise;
    set_ev[B_ERR] = |err_evt;
  end

  assign wr_sts = reg_we && (reg_addr == A_STATUS);
  assign wr_en  = reg_we && (reg_addr == A_ENABLE);

  mic_status_bank #(.N(N_SRC)) u_bank (
    .clk(clk), .rst(rst), .set_ev(set_ev),
    .clr_we(wr_sts), .clr_mask(reg_wdata[N_SRC-1:0]),
    .en_we(wr_en), .en_wdata(reg_wdata[N_SRC-1:0]),
    .sts_q(sts), .en_q(en), .irq_q(irq));

  assign pend = sts & en;

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      reg_rdata <= '0;
      case (mic_addr_e'(reg_addr))
        A_SND_THR: reg_rdata[TH_W-1:0]  <= snd_thr_q;
        A_RCV_THR: reg_rdata[TH_W-1:0]  <= rcv_thr_q;
        A_STATUS:  reg_rdata[N_SRC-1:0] <= sts;
        A_ENABLE:  reg_rdata[N_SRC-1:0] <= en;
        A_PEND:    reg_rdata[N_SRC-1:0] <= pend;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  p_err_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (|err_evt) |=> sts[B_ERR]);
  p_level_range_r1: assert property (@(posedge clk) disable iff (rst)
    (snd_level <= LVL_W'(DEPTH)) && (rcv_level <= LVL_W'(DEPTH)));
  p_thr_write_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_RCV_THR) |=> (rcv_thr_q == $past(reg_wdata[TH_W-1:0])));
endmodule

// File: tb/tb_mbx_irq_ctrl.sv
module tb_mbx_irq_ctrl;
  localparam int DEPTH = 16;
  localparam int ERR_W = 2;
  localparam int DW    = 32;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] snd_level = '0, rcv_level = '0;
  logic [ERR_W-1:0] err_evt = '0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          snd_act, rcv_act, irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_req = 1'b0, chk_q = 1'b0;

  always #2.5 clk = ~clk;

  mbx_irq_ctrl #(.DEPTH(DEPTH), .ERR_W(ERR_W), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .snd_level(snd_level), .rcv_level(rcv_level),
    .err_evt(err_evt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .snd_act(snd_act), .rcv_act(rcv_act), .irq(irq));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(posedge clk) chk_q <= rd_req;
  always @(negedge clk) begin
    if (chk_q && exp_q.size() > 0) begin
      automatic logic [DW-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, reg_rdata, e);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk); reg_addr = a; exp_q.push_back(e); tag_q.push_back(t); rd_req = 1'b1;
    @(posedge clk); #1 rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic setlvl(input int s, input int r);
    @(negedge clk); snd_level = LW'(s); rcv_level = LW'(r);
    @(posedge clk); #1;
  endtask

  task automatic idle1();
    @(posedge clk); #1;
  endtask

  task automatic err_pulse(input logic [ERR_W-1:0] v);
    @(negedge clk); err_evt = v;
    @(posedge clk); #1 err_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 irq in reset", {31'b0, irq}, 0);
    chk("R12 snd_act in reset", {31'b0, snd_act}, 0);
    chk("R12 rcv_act in reset", {31'b0, rcv_act}, 0);
    chk("R12 rdata in reset", reg_rdata, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 snd_act level0 thr0", {31'b0, snd_act}, 1);
    chk("R1 rcv_act level0 thr0", {31'b0, rcv_act}, 0);
    rd(3'd2, 32'h1, "R4 status bit0 after reset");
    rd(3'd3, 32'h0, "R12 enable reset");
    rd(3'd0, 32'h0, "R3 send thr reset");
    rd(3'd1, 32'h0, "R3 recv thr reset");
    chk("R9 irq masked by enable 0", {31'b0, irq}, 0);

    wr(3'd2, 32'h1);
    rd(3'd2, 32'h0, "R6 w1c clears bit0");

    setlvl(0, 3);
    @(negedge clk);
    chk("R1 rcv_act 3>0", {31'b0, rcv_act}, 1);
    rd(3'd2, 32'h2, "R4 status bit1 on recv rise");
    wr(3'd2, 32'h4);
    rd(3'd2, 32'h2, "R6 writing other bits leaves bit1");

    wr(3'd1, 32'h5);
    rd(3'd1, 32'h5, "R3 recv thr readback");
    chk("R1 rcv_act 3<=5", {31'b0, rcv_act}, 0);
    wr(3'd2, 32'h2);
    rd(3'd2, 32'h0, "R6 clear bit1");
    setlvl(0, 5);
    @(negedge clk);
    chk("R1 rcv_act equal boundary", {31'b0, rcv_act}, 0);
    setlvl(0, 6);
    @(negedge clk);
    chk("R1 rcv_act 6>5", {31'b0, rcv_act}, 1);
    rd(3'd2, 32'h2, "R4 recv rise at boundary+1");
    wr(3'd1, 32'hFFFF_FFF5);
    rd(3'd1, 32'h5, "R3 upper threshold bits dropped");
    wr(3'd2, 32'h7);
    rd(3'd2, 32'h0, "R6 clear all");

    setlvl(1, 6);
    @(negedge clk);
    chk("R2 snd_act 1>0", {31'b0, snd_act}, 0);
    wr(3'd0, 32'h1);
    idle1();
    @(negedge clk);
    chk("R10 snd_act after thr write", {31'b0, snd_act}, 1);
    rd(3'd2, 32'h1, "R10 status bit0 from thr write");
    setlvl(2, 6);
    @(negedge clk);
    chk("R2 snd_act 2>1", {31'b0, snd_act}, 0);
    setlvl(1, 6);
    @(negedge clk);
    chk("R2 snd_act equal boundary", {31'b0, snd_act}, 1);
    wr(3'd2, 32'h7);
    rd(3'd2, 32'h0, "R6 clear all again");

    wr(3'd3, 32'h2);
    rd(3'd3, 32'h2, "R8 enable readback");
    setlvl(1, 0);
    setlvl(1, 7);
    @(negedge clk);
    chk("R9 irq one cycle later (not yet)", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R9 irq asserted", {31'b0, irq}, 1);
    rd(3'd4, 32'h2, "R8 pending = status & enable");
    wr(3'd4, 32'h0);
    rd(3'd4, 32'h2, "R8 pending write ignored");
    wr(3'd2, 32'h2);
    idle1();
    @(negedge clk);
    chk("R9 irq drops after clear", {31'b0, irq}, 0);

    wr(3'd3, 32'h4);
    err_pulse(2'b01);
    idle1();
    @(negedge clk);
    chk("R5 irq from error", {31'b0, irq}, 1);
    rd(3'd2, 32'h4, "R5 status bit2 from err0");
    wr(3'd2, 32'h4);
    rd(3'd2, 32'h0, "R6 clear bit2");
    err_pulse(2'b10);
    rd(3'd2, 32'h4, "R5 status bit2 from err1");

    @(negedge clk); reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h4; err_evt = 2'b10;
    @(posedge clk); #1 reg_we = 1'b0; err_evt = '0;
    rd(3'd2, 32'h4, "R7 set wins over clear");
    wr(3'd2, 32'h4);
    rd(3'd2, 32'h0, "R6 clear after collision");

    wr(3'd3, 32'hFFFF_FFF8);
    rd(3'd3, 32'h0, "R8 enable upper bits dropped");
    rd(3'd5, 32'h0, "R11 unmapped address 5");
    rd(3'd7, 32'h0, "R11 unmapped address 7");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule